// File: doc/BRIEF.md
# UART with Automatic Flow Control

A full-duplex asynchronous serial port with one transmit line, one receive line and an RTS/CTS handshake pair. Every frame has one start bit, eight data bits and one stop bit, with no parity. Data goes out least significant bit first, and the line idles high. Bytes enter and leave the block on byte-wide valid/ready streams. A small FIFO sits in each direction.

The line rate comes from a divisor of the system clock. The bit period is 16 × divisor clock cycles. At reset the divisor is the value nearest to CLK_HZ / (16 × 115200), so the port starts at 115200 bps whatever the clock frequency. Software can change the divisor at run time with a one-cycle write strobe. The 16-bit divisor covers the rates from 9600 bps up to 4000 kbps. The transmitter and the receiver each capture the divisor when a frame begins, so a write during a frame has no effect until the next frame boundary.

The receiver runs on 16 ticks per bit. It confirms a start bit at mid-bit and samples each data bit and the stop bit at its centre. It flags a missing stop bit and a byte lost to a full FIFO. When automatic flow control is enabled, CTS gates the start of new transmit frames. RTS then follows the fill level of the receive FIFO against a high-water mark.

Top module: `serial_port_fc`

## Requirements
- R1: After reset, txd_o is 1, rts_no is 0, tx_ready_o is 1 and rx_valid_o is 0.
- R2: A transmitted frame has the following shape, with each bit lasting exactly 16 × divisor cycles:
  - a 0 start bit;
  - data bits 0 to 7, least significant first;
  - a 1 stop bit.
- R3: At reset the divisor is (CLK_HZ + 8×RESET_BAUD) / (16×RESET_BAUD), rounded down. With the default parameters this is 109, which gives a 1744-cycle bit.
- R4: A div_wr_i strobe with a nonzero div_i loads a new divisor. A strobe with div_i equal to 0 is ignored.
- R5: A divisor written during a frame leaves that frame's bit period unchanged. It applies from the next frame onwards.
- R6: The receiver confirms the start bit at mid-bit and samples the data bits at their centres. It delivers the received bytes in arrival order on the rx stream.
- R7: If the stop bit is sampled as 0, the block drops the byte and pulses frame_err_o for one cycle. The receiver re-arms only after the line returns high.
- R8: If a complete byte arrives while the receive FIFO already holds RX_DEPTH bytes, the block drops that byte and pulses overrun_o for one cycle. The bytes already stored are kept.
- R9: With afc_en_i at 1 and cts_ni at 1, no new frame starts. A frame that is already in progress completes unchanged.
- R10: With afc_en_i at 0, cts_ni has no effect and rts_no stays at 0.
- R11: With afc_en_i at 1, rts_no goes to 1 once the receive FIFO holds RX_HIGH or more bytes. It returns to 0 when the count falls below RX_HIGH.
- R12: tx_ready_o is 0 while the transmit FIFO holds TX_DEPTH bytes. Bytes are transmitted in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_wr_i | input | 1 | Divisor write strobe |
| div_i | input | DIV_W | New divisor value |
| afc_en_i | input | 1 | Enables automatic flow control |
| tx_data_i | input | 8 | Transmit byte |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Transmit FIFO can accept a byte |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte available |
| rx_ready_i | input | 1 | Consumer takes the received byte |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| rts_no | output | 1 | Request to send, active low |
| cts_ni | input | 1 | Clear to send, active low |
| frame_err_o | output | 1 | One-cycle pulse on a missing stop bit |
| overrun_o | output | 1 | One-cycle pulse when a byte is dropped on a full FIFO |

## Verification
Faults show up at the ports in the following ways:
- **Bit timing.** A divisor captured at the wrong moment, or a wrong reset divisor, changes the width of the very next start bit. The bench measures that width to the cycle.
- **Transmit shift.** A shift-register or bit-counter fault corrupts the byte recovered by the bench's own receiver within one frame.
- **Receive sampling.** A fault in the receive sampling point or the state sequencing shows up as a wrong byte or a missing byte on the rx stream.
- **Error flags.** Such faults also show up as a frame_err_o or overrun_o pulse that should not occur, within one frame.
- **Flow control.** A fault in flow control shows up as a frame starting while CTS is deasserted. It can also show up as the wrong rts_no level a few cycles after the receive FIFO crosses the high-water mark.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_e;

  // nearest divisor for 16x oversampling
  function automatic int div_for(input int clk_hz, input int baud);
    return (clk_hz + 8 * baud) / (16 * baud);
  endfunction

endpackage

// File: rtl/sp_fifo.sv
module sp_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    count_o
);

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign do_push = push_i && (cnt_q != FULL_C);
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rptr_q];
  assign count_o = cnt_q;

  // R8
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == FULL_C && !pop_i) |=> cnt_q == FULL_C);
  // R12
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_C);

endmodule

// File: rtl/sp_tx.sv
module sp_tx #(
  parameter int DIV_W = 16,
  localparam int CW = DIV_W + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             afc_en_i,
  input  logic             cts_ok_i,
  input  logic [7:0]       data_i,
  input  logic             avail_i,
  output logic             pop_o,
  output logic             txd_o
);

  logic          busy_q;
  logic [9:0]    sh_q;
  logic [3:0]    idx_q;
  logic [CW-1:0] cnt_q, len_q;
  logic          start;

  assign start = !busy_q && avail_i && (!afc_en_i || cts_ok_i);
  assign pop_o = start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      idx_q  <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      sh_q   <= {1'b1, data_i, 1'b0};
      idx_q  <= '0;
      cnt_q  <= '0;
      len_q  <= {div_i, 4'b0000};   // bit period latched per frame
    end else if (busy_q) begin
      if (cnt_q == len_q - 1'b1) begin
        cnt_q <= '0;
        sh_q  <= {1'b1, sh_q[9:1]};
        if (idx_q == 4'd9) busy_q <= 1'b0;
        else               idx_q  <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign txd_o = sh_q[0];

  // R9
  cts_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(!afc_en_i || cts_ok_i));
  // R5
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(len_q));
  // R2
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> idx_q <= 4'd9);

endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rxd_i,
  input  logic             full_i,
  output logic [7:0]       data_o,
  output logic             push_o,
  output logic             frame_err_o,
  output logic             overrun_o
);

  rx_state_e        st_q;
  logic [DIV_W-1:0] div_q, pre_q;
  logic [3:0]       os_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic             tick, stop_smp;

  assign tick     = (pre_q == div_q - 1'b1);
  assign stop_smp = (st_q == RX_STOP) && tick && (os_q == 4'd15);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RX_IDLE;
      div_q <= DIV_W'(1);
      pre_q <= '0;
      os_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      if (st_q != RX_IDLE && st_q != RX_BREAK) begin
        if (tick) begin
          pre_q <= '0;
          os_q  <= os_q + 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
      case (st_q)
        RX_IDLE: if (!rxd_i) begin
          st_q  <= RX_START;
          div_q <= div_i;
          pre_q <= '0;
          os_q  <= '0;
          bit_q <= '0;
        end
        RX_START: if (tick && os_q == 4'd7) begin
          if (!rxd_i) begin
            st_q <= RX_DATA;
            os_q <= '0;
          end else begin
            st_q <= RX_IDLE;   // glitch, not a start bit
          end
        end
        RX_DATA: if (tick && os_q == 4'd15) begin
          sh_q  <= {rxd_i, sh_q[7:1]};
          bit_q <= bit_q + 1'b1;
          if (bit_q == 3'd7) st_q <= RX_STOP;
        end
        RX_STOP: if (stop_smp) st_q <= rxd_i ? RX_IDLE : RX_BREAK;
        RX_BREAK: if (rxd_i) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign data_o      = sh_q;
  assign push_o      = stop_smp && rxd_i && !full_i;
  assign overrun_o   = stop_smp && rxd_i && full_i;
  assign frame_err_o = stop_smp && !rxd_i;

  // R7
  ferr_nopush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !push_o);
  // R8
  ovr_nopush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> (!push_o && full_i));
  // R5
  rx_div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != RX_IDLE && $past(st_q) != RX_IDLE) |-> $stable(div_q));

endmodule

// File: rtl/serial_port_fc.sv
module serial_port_fc
  import sp_pkg::*;
#(
  parameter int CLK_HZ     = 200_000_000,
  parameter int RESET_BAUD = 115200,
  parameter int DIV_W      = 16,
  parameter int TX_DEPTH   = 4,
  parameter int RX_DEPTH   = 8,
  parameter int RX_HIGH    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_wr_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             afc_en_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  output logic             txd_o,
  input  logic             rxd_i,
  output logic             rts_no,
  input  logic             cts_ni,
  output logic             frame_err_o,
  output logic             overrun_o
);

  localparam int TX_CW = $clog2(TX_DEPTH + 1);
  localparam int RX_CW = $clog2(RX_DEPTH + 1);
  localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(div_for(CLK_HZ, RESET_BAUD));
  localparam logic [TX_CW-1:0] TX_FULL_C = TX_CW'(TX_DEPTH);
  localparam logic [RX_CW-1:0] RX_FULL_C = RX_CW'(RX_DEPTH);
  localparam logic [RX_CW-1:0] RX_HIGH_C = RX_CW'(RX_HIGH);

  logic [DIV_W-1:0] div_q;
  logic [1:0]       cts_sync_q, rxd_sync_q;
  logic             rts_q;
  logic [TX_CW-1:0] tx_cnt;
  logic [RX_CW-1:0] rx_cnt;
  logic [7:0]       tx_head, rx_byte;
  logic             tx_pop, rx_push;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q      <= DIV_RESET;
      cts_sync_q <= 2'b11;
      rxd_sync_q <= 2'b11;
      rts_q      <= 1'b0;
    end else begin
      if (div_wr_i && div_i != '0) div_q <= div_i;
      cts_sync_q <= {cts_sync_q[0], cts_ni};
      rxd_sync_q <= {rxd_sync_q[0], rxd_i};
      rts_q      <= afc_en_i && (rx_cnt >= RX_HIGH_C);
    end
  end

  assign tx_ready_o = (tx_cnt != TX_FULL_C);
  assign rx_valid_o = (rx_cnt != '0);
  assign rts_no     = rts_q;

  sp_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_valid_i),
    .wdata_i (tx_data_i),
    .pop_i   (tx_pop),
    .rdata_o (tx_head),
    .count_o (tx_cnt)
  );

  sp_tx #(.DIV_W(DIV_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_i    (div_q),
    .afc_en_i (afc_en_i),
    .cts_ok_i (!cts_sync_q[1]),
    .data_i   (tx_head),
    .avail_i  (tx_cnt != '0),
    .pop_o    (tx_pop),
    .txd_o    (txd_o)
  );

  sp_rx #(.DIV_W(DIV_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .div_i       (div_q),
    .rxd_i       (rxd_sync_q[1]),
    .full_i      (rx_cnt == RX_FULL_C),
    .data_o      (rx_byte),
    .push_o      (rx_push),
    .frame_err_o (frame_err_o),
    .overrun_o   (overrun_o)
  );

  sp_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .wdata_i (rx_byte),
    .pop_i   (rx_ready_i),
    .rdata_o (rx_data_o),
    .count_o (rx_cnt)
  );

  // R11
  rts_hw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (afc_en_i && rx_cnt >= RX_HIGH_C) |=> rts_no);
  // R10
  rts_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !afc_en_i |=> !rts_no);
  // R4
  div_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_wr_i && div_i == '0) |=> $stable(div_q));

endmodule

// File: tb/serial_port_fc_tb.sv
`timescale 1ns/1ps
module serial_port_fc_tb;

  localparam int CLK_HZ = 200_000_000;
  localparam int BAUD   = 115200;
  localparam int RX_DEP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_wr = 1'b0;
  logic [15:0] div_v = '0;
  logic afc_en = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [7:0] rx_data;
  logic rx_valid;
  logic rx_ready = 1'b1;
  logic txd;
  logic rxd = 1'b1;
  logic rts_n;
  logic cts_n = 1'b0;
  logic ferr, ovr;

  int checks = 0, fails = 0;
  int rx_n = 0, ferr_n = 0, ovr_n = 0;
  logic [7:0] rx_got [256];
  logic [7:0] exp_q [64];

  always #2.5 clk = ~clk;

  serial_port_fc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .div_wr_i(div_wr), .div_i(div_v),
    .afc_en_i(afc_en), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_ready_i(rx_ready), .txd_o(txd), .rxd_i(rxd), .rts_no(rts_n),
    .cts_ni(cts_n), .frame_err_o(ferr), .overrun_o(ovr)
  );

  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      rx_got[rx_n[7:0]] = rx_data;
      rx_n++;
    end
    if (rst_n && ferr) ferr_n++;
    if (rst_n && ovr)  ovr_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_tb();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic int bit_len(input int d);
    return 16 * d;
  endfunction

  task automatic wr_div(input int v);
    @(negedge clk); div_v = 16'(v); div_wr = 1'b1;
    @(negedge clk); div_wr = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic get_tx(input int per, output logic [7:0] b, output logic stp);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    repeat (per / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (per) @(negedge clk);
      b[i] = txd;
    end
    repeat (per) @(negedge clk);
    stp = txd;
  endtask

  task automatic low_run(output int n);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    n = 0;
    while (txd === 1'b0) begin n++; @(negedge clk); end
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stp, input int per);
    @(negedge clk); rxd = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (per) @(negedge clk);
    end
    rxd = stp;
    repeat (per) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk); #1 rx_ready = v;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_tb();
  end

  initial begin
    logic [7:0] b;
    logic s;
    int n, base, p, hi;
    void'($urandom(32'd2718));

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txd === 1'b1, "R1 txd", txd, 1);
    chk(rts_n === 1'b0, "R1 rts", rts_n, 0);
    chk(tx_ready === 1'b1, "R1 tx_ready", tx_ready, 1);
    chk(rx_valid === 1'b0, "R1 rx_valid", rx_valid, 0);

    // R3 reset rate
    fork
      push_tx(8'h55);
      low_run(n);
    join
    chk(n == bit_len((CLK_HZ + 8 * BAUD) / (16 * BAUD)), "R3 reset bit period", n, 1744);
    repeat (10 * 1744) @(negedge clk);

    // R4 new divisor
    wr_div(2); p = bit_len(2);
    fork
      push_tx(8'h01);
      low_run(n);
    join
    chk(n == p, "R4 bit period after write", n, p);
    repeat (10 * p) @(negedge clk);

    // R2 / R12 random transmit stream
    for (int i = 0; i < 20; i++) exp_q[i] = 8'($urandom());
    exp_q[0] = 8'h00; exp_q[1] = 8'hFF;
    fork
      for (int i = 0; i < 20; i++) push_tx(exp_q[i]);
      for (int i = 0; i < 20; i++) begin
        get_tx(p, b, s);
        chk(b == exp_q[i], "R2 tx byte", b, exp_q[i]);
        chk(s == 1'b1, "R2 stop bit", s, 1);
      end
    join

    // R6 random receive stream
    base = rx_n;
    for (int i = 0; i < 20; i++) begin
      exp_q[i] = 8'($urandom());
      send_rx(exp_q[i], 1'b1, p);
    end
    repeat (4) @(negedge clk);
    chk(rx_n - base == 20, "R6 rx count", rx_n - base, 20);
    for (int i = 0; i < 20; i++)
      chk(rx_got[8'(base + i)] == exp_q[i], "R6 rx byte", rx_got[8'(base + i)], exp_q[i]);

    // R7 framing error, then recovery
    base = rx_n; n = ferr_n;
    send_rx(8'hA5, 1'b0, p);
    repeat (2 * p) @(negedge clk);
    chk(ferr_n == n + 1, "R7 frame_err pulses", ferr_n - n, 1);
    chk(rx_n == base, "R7 byte dropped", rx_n - base, 0);
    send_rx(8'h3C, 1'b1, p);
    repeat (4) @(negedge clk);
    chk(rx_n == base + 1 && rx_got[8'(base)] == 8'h3C, "R7 recovery", rx_got[8'(base)], 8'h3C);

    // R9 / R12 CTS blocks frames, FIFO fills
    afc_en = 1'b1; cts_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      exp_q[i] = 8'(8'h90 + i);
      push_tx(exp_q[i]);
    end
    hi = 0;
    for (int i = 0; i < 30 * p; i++) begin
      @(negedge clk);
      if (txd === 1'b1) hi++;
    end
    chk(hi == 30 * p, "R9 idle while cts off", hi, 30 * p);
    chk(tx_ready === 1'b0, "R12 tx_ready full", tx_ready, 0);
    cts_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      get_tx(p, b, s);
      chk(b == exp_q[i], "R12 tx order", b, exp_q[i]);
    end
    repeat (p) @(negedge clk);

    // R9 frame in progress completes
    fork
      push_tx(8'hC3);
      begin
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        repeat (p + 3) @(negedge clk);
        cts_n = 1'b1;
      end
      get_tx(p, b, s);
    join
    chk(b == 8'hC3 && s == 1'b1, "R9 frame completes", b, 8'hC3);
    repeat (p) @(negedge clk);
    push_tx(8'h5A);
    hi = 0;
    for (int i = 0; i < 20 * p; i++) begin
      @(negedge clk);
      if (txd === 1'b1) hi++;
    end
    chk(hi == 20 * p, "R9 next frame held", hi, 20 * p);
    cts_n = 1'b0;
    get_tx(p, b, s);
    chk(b == 8'h5A, "R9 released byte", b, 8'h5A);
    repeat (p) @(negedge clk);

    // R10 flow control off ignores CTS
    afc_en = 1'b0; cts_n = 1'b1;
    repeat (5) @(negedge clk);
    fork
      push_tx(8'h77);
      get_tx(p, b, s);
    join
    chk(b == 8'h77, "R10 cts ignored", b, 8'h77);
    cts_n = 1'b0;
    repeat (p) @(negedge clk);

    // R11 RTS high-water mark
    afc_en = 1'b1;
    set_ready(1'b0);
    base = rx_n;
    for (int i = 0; i < 5; i++) begin
      exp_q[i] = 8'($urandom());
      send_rx(exp_q[i], 1'b1, p);
    end
    repeat (3) @(negedge clk);
    chk(rts_n === 1'b0, "R11 rts below mark", rts_n, 0);
    exp_q[5] = 8'hE1;
    send_rx(exp_q[5], 1'b1, p);
    repeat (3) @(negedge clk);
    chk(rts_n === 1'b1, "R11 rts at mark", rts_n, 1);
    afc_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(rts_n === 1'b0, "R10 rts held low", rts_n, 0);
    afc_en = 1'b1;
    repeat (3) @(negedge clk);
    set_ready(1'b1);
    set_ready(1'b0);
    repeat (3) @(negedge clk);
    chk(rts_n === 1'b0, "R11 rts after drain", rts_n, 0);
    chk(rx_n == base + 1 && rx_got[8'(base)] == exp_q[0], "R11 popped byte", rx_got[8'(base)], exp_q[0]);

    // R8 overrun: 5 stored, add 3 to fill, 9th dropped
    for (int i = 6; i < 9; i++) begin
      exp_q[i] = 8'($urandom());
      send_rx(exp_q[i], 1'b1, p);
    end
    n = ovr_n;
    send_rx(8'hBD, 1'b1, p);
    repeat (3) @(negedge clk);
    chk(ovr_n == n + 1, "R8 overrun pulses", ovr_n - n, 1);
    base = rx_n;
    set_ready(1'b1);
    repeat (RX_DEP + 4) @(negedge clk);
    chk(rx_n - base == RX_DEP, "R8 stored count", rx_n - base, RX_DEP);
    for (int i = 0; i < RX_DEP; i++)
      chk(rx_got[8'(base + i)] == exp_q[i + 1], "R8 kept byte", rx_got[8'(base + i)], exp_q[i + 1]);

    // R5 divisor written mid-frame
    fork
      push_tx(8'h69);
      begin
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        repeat (2 * p) @(negedge clk);
        wr_div(4);
      end
      get_tx(p, b, s);
    join
    chk(b == 8'h69 && s == 1'b1, "R5 frame keeps old rate", b, 8'h69);
    repeat (p) @(negedge clk);
    fork
      push_tx(8'h01);
      low_run(n);
    join
    chk(n == bit_len(4), "R5 next frame new rate", n, bit_len(4));
    repeat (10 * bit_len(4)) @(negedge clk);

    // R4 zero write ignored
    wr_div(0);
    fork
      push_tx(8'h01);
      low_run(n);
    join
    chk(n == bit_len(4), "R4 zero divisor ignored", n, bit_len(4));
    repeat (10 * bit_len(4)) @(negedge clk);

    finish_tb();
  end

endmodule